// File: doc/BRIEF.md
# Key-Sequenced Register Write Guard

This block holds a small bank of timekeeping registers and shields four of them (a timer control word, seconds, minutes and hours) from stray bus writes. Protection is lifted only when software writes three two-bit codes in a fixed order to a key field. The key field has its own write strobe and value. A wrong code at any point of the series re-arms the lock. Writing the lock code while open locks the bank again.

The register bus has a write strobe, an address and write data. Read data is returned combinationally for the addressed register. A per-register gate output pulses for each write that the bank accepts. Both strobes act on their rising edge, so a strobe held high over several cycles counts as one write. The key field always reads back as zero, so the unlock state cannot be learned by polling.

Top module: `rtc_wprot_guard`

## Requirements
- R1: After reset the guard is locked, every register reads 0 and no gate output is high.
- R2: While locked (internal code 2'b11), a key write of 2'b10 moves to the first step. Any other key value leaves the guard locked.
- R3: The key series 2'b10, then 2'b01, then 2'b00, each as its own strobe, unlocks the guard. After that, writes to addresses 0 to 3 (control, seconds, minutes, hours) are stored.
- R4: At the second or third step of the series, any key value other than the expected one returns the guard to locked.
- R5: While unlocked, a key write of 2'b11 locks the guard. Any other key value keeps it unlocked.
- R6: While locked, a bus write to addresses 0 to 3 is dropped without any error. The register keeps its old value and its gate stays low.
- R7: Addresses 4 (key control word) and 5 (scratch) accept writes in every state. At address 4, data bits [7:2] are stored.
- R8: Bits [1:0] of address 4 always read as 2'b00, whatever the guard state.
- R9: A key or bus strobe held high over several cycles acts once, on its first cycle. Value changes made while the strobe stays high are ignored.
- R10: When a key write and a bus write are accepted in the same cycle, the bus write is judged against the guard state from before the key write.
- R11: `reg_wgate[i]` is high, for one cycle, exactly when a bus write to address i is accepted.
- R12: Addresses 6 and 7 read 0, accept no write and raise no gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr | input | 1 | Key field write strobe (rising edge counts) |
| key_val | input | 2 | Key value being written |
| bus_wr | input | 1 | Register write strobe (rising edge counts) |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| reg_wgate | output | 6 | Per-register accepted-write pulse |

## Verification
Two events can land in one cycle: a key write that changes the lock state and a bus write to a shielded register. The bench drives both strobes on the same clock at two points. The first is the final unlock step, where the bus write must be dropped. The second is the relock code while open, where the bus write must land. The result is judged from the gate output in that cycle and from a read-back afterwards, against a behavioural model that applies the bus write before the key transition.

// File: rtl/rtc_wp_pkg.sv
package rtc_wp_pkg;
   localparam int NUM_REGS    = 6;
   localparam int IDX_CTRL    = 0;
   localparam int IDX_SEC     = 1;
   localparam int IDX_MIN     = 2;
   localparam int IDX_HOUR    = 3;
   localparam int IDX_KEYCTL  = 4;
   localparam int IDX_SCRATCH = 5;
   localparam int KEY_W       = 2;

   typedef enum logic [KEY_W-1:0] {
      KEY_OPEN   = 2'b00,
      KEY_STEP2  = 2'b01,
      KEY_STEP1  = 2'b10,
      KEY_LOCKED = 2'b11
   } key_state_e;
endpackage

// File: rtl/rtc_wp_pulse.sv
module rtc_wp_pulse #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] fire
);
   initial begin : g_chk
      assert (W >= 1) else $error("rtc_wp_pulse: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= lvl[b];
      end
      assign fire[b] = lvl[b] & ~lvl_q;

      // R9: one accepted write per strobe, never two cycles in a row
      p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
         fire[b] |=> !fire[b]);
   end
endmodule

// File: rtl/rtc_wp_keyfsm.sv
module rtc_wp_keyfsm
   import rtc_wp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [KEY_W-1:0] key_val,
   output logic             unlocked
);
   key_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      if (fire) begin
         unique case (state)
            KEY_LOCKED: state_nx = (key_val == 2'b10) ? KEY_STEP1 : KEY_LOCKED;
            KEY_STEP1:  state_nx = (key_val == 2'b01) ? KEY_STEP2 : KEY_LOCKED;
            KEY_STEP2:  state_nx = (key_val == 2'b00) ? KEY_OPEN  : KEY_LOCKED;
            KEY_OPEN:   state_nx = (key_val == 2'b11) ? KEY_LOCKED : KEY_OPEN;
            default:    state_nx = KEY_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KEY_LOCKED;
      else        state <= state_nx;
   end

   assign unlocked = (state == KEY_OPEN);

   // R2: from locked only 2'b10 leaves the locked state
   p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && state == KEY_LOCKED && key_val != 2'b10) |=> state == KEY_LOCKED);
   // R3: the open state is entered only from the last step with code 2'b00
   p_open_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == KEY_OPEN && $past(state) != KEY_OPEN) |->
      ($past(state) == KEY_STEP2 && $past(fire) && $past(key_val) == 2'b00));
   // R4: a wrong code mid-series re-arms the lock
   p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ((state == KEY_STEP1 && key_val != 2'b01) ||
                (state == KEY_STEP2 && key_val != 2'b00))) |=> state == KEY_LOCKED);
   // R5: lock code while open relocks, other codes keep it open
   p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && state == KEY_OPEN && key_val == 2'b11) |=> state == KEY_LOCKED);
   p_stay_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && state == KEY_OPEN && key_val != 2'b11) |=> state == KEY_OPEN);
   // R9: without an accepted key write the state never moves
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(state));
endmodule

// File: rtl/rtc_wp_regs.sv
module rtc_wp_regs #(
   parameter int                  DATA_W    = 8,
   parameter int                  ADDR_W    = 3,
   parameter int                  NREGS     = 6,
   parameter int                  KEY_IDX   = 4,
   parameter int                  KEY_W     = 2,
   parameter logic [NREGS-1:0]    PROT_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              unlocked,
   output logic [NREGS-1:0]  gate,
   output logic [DATA_W-1:0] rd_data
);
   localparam int UPPER_W = DATA_W - KEY_W;

   logic [DATA_W-1:0] q   [NREGS];
   logic [NREGS-1:0]  hit;

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      assign hit[i] = (addr == ADDR_W'(i));

      if (PROT_MASK[i]) begin : g_guarded
         assign gate[i] = wr_fire & hit[i] & unlocked;
      end else begin : g_open
         assign gate[i] = wr_fire & hit[i];
      end

      if (i == KEY_IDX) begin : g_keyword
         logic [UPPER_W-1:0] upper;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       upper <= '0;
            else if (gate[i]) upper <= wdata[DATA_W-1:KEY_W];
         end
         assign q[i] = {upper, {KEY_W{1'b0}}};
      end else begin : g_plain
         logic [DATA_W-1:0] store;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       store <= '0;
            else if (gate[i]) store <= wdata;
         end
         assign q[i] = store;
      end

      if (PROT_MASK[i]) begin : g_chk_guard
         // R6: while locked a shielded register never changes
         p_locked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !unlocked |=> $stable(q[i]));
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREGS; k++) begin
         if (hit[k]) rd_data = q[k];
      end
   end

   // R8: key bits read back as zero
   p_keyrd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(KEY_IDX)) |-> rd_data[KEY_W-1:0] == '0);
   // R11: at most one register gate per cycle
   p_gate_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate));
endmodule

// File: rtl/rtc_wprot_guard.sv
module rtc_wprot_guard
   import rtc_wp_pkg::*;
#(
   parameter int                   DATA_W    = 8,
   parameter int                   ADDR_W    = 3,
   parameter logic [NUM_REGS-1:0]  PROT_MASK = 6'b001111
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                key_wr,
   input  logic [KEY_W-1:0]    key_val,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_REGS-1:0] reg_wgate
);
   localparam int STROBES = 2;

   initial begin : g_elab
      assert (DATA_W > KEY_W) else $error("rtc_wprot_guard: DATA_W too small for key field");
      assert ((1 << ADDR_W) >= NUM_REGS) else $error("rtc_wprot_guard: ADDR_W too small");
      assert (PROT_MASK[IDX_KEYCTL] == 1'b0) else $error("rtc_wprot_guard: key word must stay writable");
   end

   logic [STROBES-1:0] fire;
   logic               unlocked;

   rtc_wp_pulse #(.W(STROBES)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   ({bus_wr, key_wr}),
      .fire  (fire)
   );

   rtc_wp_keyfsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire[0]),
      .key_val  (key_val),
      .unlocked (unlocked)
   );

   rtc_wp_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .NREGS     (NUM_REGS),
      .KEY_IDX   (IDX_KEYCTL),
      .KEY_W     (KEY_W),
      .PROT_MASK (PROT_MASK)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_fire  (fire[1]),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .unlocked (unlocked),
      .gate     (reg_wgate),
      .rd_data  (bus_rdata)
   );

   // R10: a shielded write in the cycle that completes the series is still blocked
   p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && fire[0]) |-> ((reg_wgate & PROT_MASK) == '0));
   // R12: addresses past the bank raise no gate
   p_oob_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) >= NUM_REGS) |-> (reg_wgate == '0 && bus_rdata == '0));
endmodule

// File: tb/rtc_wprot_guard_bench.sv
module rtc_wprot_guard_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_wr = 1'b0;
   logic [1:0] key_val = 2'b00;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic [5:0] reg_wgate;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural model
   int         m_st = 3;
   logic [7:0] m_reg [6];
   bit         m_kq = 0;
   bit         m_bq = 0;

   rtc_wprot_guard u_rtc_wprot_guard (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(key_val),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .reg_wgate(reg_wgate)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic bit is_prot(int a);
      return (a < 4);
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one clock: drive, compare against model, advance model
   task automatic cyc(bit kw, logic [1:0] kv, bit bw, logic [2:0] ba, logic [7:0] bd, string tag);
      logic [7:0] e_rd;
      logic [5:0] e_gate;
      bit kacc, bacc;
      key_wr = kw; key_val = kv; bus_wr = bw; bus_addr = ba; bus_wdata = bd;
      #1;
      kacc = kw && !m_kq;
      bacc = bw && !m_bq;
      e_gate = '0;
      if (bacc && ba < 6 && (!is_prot(ba) || m_st == 0)) e_gate[ba] = 1'b1;
      e_rd = (ba < 6) ? ((ba == 4) ? (m_reg[ba] & 8'hFC) : m_reg[ba]) : 8'h00;
      chk(tag, "rdata", bus_rdata, e_rd);
      chk(tag, "gate", {2'b00, reg_wgate}, {2'b00, e_gate});
      @(posedge clk);
      if (e_gate != 0) m_reg[ba] = (ba == 4) ? (bd & 8'hFC) : bd;
      if (kacc) begin
         case (m_st)
            3: m_st = (kv == 2'b10) ? 2 : 3;
            2: m_st = (kv == 2'b01) ? 1 : 3;
            1: m_st = (kv == 2'b00) ? 0 : 3;
            default: m_st = (kv == 2'b11) ? 3 : 0;
         endcase
      end
      m_kq = kw; m_bq = bw;
      @(negedge clk);
   endtask

   task automatic idle(string tag);
      cyc(0, 2'b00, 0, 3'd0, 8'h00, tag);
   endtask

   task automatic key(logic [1:0] v, string tag);
      cyc(1, v, 0, 3'd0, 8'h00, tag);
      idle(tag);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
      cyc(0, 2'b00, 1, a, d, tag);
      cyc(0, 2'b00, 0, a, 8'h00, tag);
   endtask

   task automatic rd(logic [2:0] a, string tag);
      cyc(0, 2'b00, 0, a, 8'h00, tag);
   endtask

   initial begin : watchdog
      #(CLK_P * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      for (int i = 0; i < 6; i++) m_reg[i] = 8'h00;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, R8 key bits, R12 out of range
      for (int a = 0; a < 8; a++) rd(3'(a), "R1");
      // R6: locked writes dropped
      wr(3'd1, 8'h3B, "R6");
      wr(3'd3, 8'h17, "R6");
      rd(3'd1, "R6");
      // R7: unprotected writes while locked, R8 key bits read 0
      wr(3'd4, 8'hFF, "R7");
      rd(3'd4, "R8");
      wr(3'd5, 8'hA5, "R7");
      rd(3'd5, "R7");
      // R2: wrong first code stays locked
      key(2'b01, "R2"); key(2'b00, "R2");
      wr(3'd0, 8'h11, "R2");
      // R4: abort at second and third step
      key(2'b10, "R4"); key(2'b11, "R4"); key(2'b00, "R4");
      wr(3'd2, 8'h22, "R4");
      key(2'b10, "R4"); key(2'b01, "R4"); key(2'b10, "R4"); key(2'b00, "R4");
      wr(3'd2, 8'h23, "R4");
      // R3: full series opens
      key(2'b10, "R3"); key(2'b01, "R3"); key(2'b00, "R3");
      wr(3'd0, 8'h5A, "R3"); wr(3'd1, 8'h30, "R3");
      wr(3'd2, 8'h45, "R3"); wr(3'd3, 8'h12, "R3");
      for (int a = 0; a < 4; a++) rd(3'(a), "R11");
      rd(3'd4, "R8");
      // R5: non-lock codes keep it open, 2'b11 relocks
      key(2'b01, "R5"); key(2'b10, "R5"); key(2'b00, "R5");
      wr(3'd1, 8'h31, "R5");
      key(2'b11, "R5");
      wr(3'd1, 8'h32, "R5");
      rd(3'd1, "R5");
      // R9: held key strobe counts once; value change while held ignored
      cyc(1, 2'b10, 0, 3'd0, 8'h00, "R9");
      cyc(1, 2'b10, 0, 3'd0, 8'h00, "R9");
      cyc(1, 2'b01, 0, 3'd0, 8'h00, "R9");
      idle("R9");
      key(2'b01, "R9"); key(2'b00, "R9");
      wr(3'd3, 8'h09, "R9");
      // R9: held bus strobe stores only the first data
      cyc(0, 2'b00, 1, 3'd5, 8'h61, "R9");
      cyc(0, 2'b00, 1, 3'd5, 8'h62, "R9");
      cyc(0, 2'b00, 1, 3'd5, 8'h63, "R9");
      rd(3'd5, "R9");
      // R10: relock code and shielded write in one cycle: write lands
      cyc(1, 2'b11, 1, 3'd2, 8'h4E, "R10");
      idle("R10");
      rd(3'd2, "R10");
      wr(3'd2, 8'h4F, "R10");
      // R10: final unlock code and shielded write in one cycle: write dropped
      key(2'b10, "R10"); key(2'b01, "R10");
      cyc(1, 2'b00, 1, 3'd0, 8'h77, "R10");
      idle("R10");
      rd(3'd0, "R10");
      wr(3'd0, 8'h78, "R10");
      rd(3'd0, "R10");
      // R12: out-of-range writes while open
      wr(3'd6, 8'hEE, "R12");
      wr(3'd7, 8'hDD, "R12");
      rd(3'd6, "R12"); rd(3'd7, "R12");
      for (int a = 0; a < 6; a++) rd(3'(a), "R12");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule